// File: doc/BRIEF.md
# CAN Acceptance Screener Bank

This block sits behind a CAN frame receiver. For each completed frame it decides whether the frame is wanted and, if so, which of a bank of message objects should take it. The receiver presents the frame's identifier, its frame-format flag (IDE), its data length code and its first two payload bytes, together with a one-cycle valid strobe. The block packs these into a 30-bit screener word. It compares that word at the same time against every object's programmable match word, and a per-object 29-bit mask can exclude single bits from the comparison.

Standard frames carry an 11-bit identifier, so the two leading payload bytes fill the rest of the screener word. A transport protocol can then screen on a message type or a sequence byte as well as on the identifier. Extended frames carry a 29-bit identifier, which fills the whole word. One registered cycle after the strobe, the block reports either an accept pulse with the index of the lowest-numbered enabled object that matched, or a reject pulse. Software or a sequencer programs the bank through a plain address/data write port.

Top module: `can_screener_bank`

## Requirements
- R1: After reset, every object is disabled and every match word and mask is zero. While reset is asserted and afterwards, `acc_valid`, `rej_valid` and `acc_index` stay low until a frame strobe is answered. A frame that arrives before any programming is rejected.
- R2: For an extended frame (`frm_ide`=1) the screener word is bit 29 = 1 and bits 28:0 = `frm_id[28:0]`.
- R3: For a standard frame (`frm_ide`=0) the screener word is bit 29 = 0, bits 28:18 = `frm_id[10:0]`, bits 17:10 = payload byte 0, bits 9:2 = payload byte 1 and bits 1:0 = 0.
- R4: A payload byte that the frame does not carry counts as zero. Byte 0 is used only when `frm_dlc` >= 1 and byte 1 only when `frm_dlc` >= 2.
- R5: An object matches when every screener bit equals its match bit, except for bits i in 0..28 whose mask bit i is 1. Bit 29 (IDE) is always compared.
- R6: An object whose enable bit is 0 never matches.
- R7: When several enabled objects match, `acc_index` gives the lowest-numbered one.
- R8: `acc_valid` is high for exactly the one cycle after a strobe that found a match, with `acc_index` valid in that cycle. `acc_index` is zero whenever `acc_valid` is low.
- R9: A strobe that finds no match gives a one-cycle `rej_valid` in the cycle after it. `acc_valid` and `rej_valid` are never high together.
- R10: A register write in the same cycle as a frame strobe is not seen by that frame, only by later frames.
- R11: The write address is {object index, selector[1:0]}. Selector 0 writes the match word from `cfg_wr_data[29:0]`, selector 1 writes the mask from `cfg_wr_data[28:0]`, selector 2 writes the enable from `cfg_wr_data[0]`, and selector 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 7 | {object index, selector} |
| cfg_wr_data | input | 32 | Write data |
| frm_valid | input | 1 | One-cycle strobe: frame fields are valid |
| frm_ide | input | 1 | 1 = extended frame, 0 = standard frame |
| frm_id | input | 29 | Identifier; standard frames use bits 10:0 |
| frm_dlc | input | 4 | Data length code |
| frm_byte0 | input | 8 | First payload byte |
| frm_byte1 | input | 8 | Second payload byte |
| acc_valid | output | 1 | Accept pulse |
| acc_index | output | 5 | Winning object index |
| rej_valid | output | 1 | Reject pulse |

## Verification
The bench builds the block with its default of 32 objects and a 32-bit write port, which puts both ends of the index range within reach. Object 0 beats object 31, objects 7 and 20 overlap, and a write to object 0 with selector 3 must leave that object as it was. At this size the full 7-bit address space is decoded. The reference model recomputes the screener word from the frame fields and scans the objects in order, so mask families, the fixed IDE comparison, payload bytes dropped by a short length code and writes that collide with a strobe all show up as cycle-exact mismatches.

// File: rtl/can_scr_pkg.sv
package can_scr_pkg;

    localparam int SCR_W     = 30;
    localparam int MASK_W    = 29;
    localparam int ID_EXT_W  = 29;
    localparam int ID_STD_W  = 11;
    localparam int BYTE_W    = 8;
    localparam int DLC_W     = 4;
    localparam int SEL_W     = 2;
    localparam int IDE_POS   = SCR_W - 1;

    typedef enum logic [SEL_W-1:0] {
        SEL_MATCH  = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_ENABLE = 2'd2,
        SEL_SPARE  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/can_scr_word_build.sv
module can_scr_word_build
    import can_scr_pkg::*;
(
    input  logic                 ide,
    input  logic [ID_EXT_W-1:0]  id,
    input  logic [DLC_W-1:0]     dlc,
    input  logic [BYTE_W-1:0]    byte0,
    input  logic [BYTE_W-1:0]    byte1,
    output logic [SCR_W-1:0]     word
);

    localparam int PAD_W = SCR_W - 1 - ID_STD_W - 2 * BYTE_W;

    logic [BYTE_W-1:0] b0_eff;
    logic [BYTE_W-1:0] b1_eff;

    always_comb begin
        // Bytes beyond the data length code are not present on the bus.
        b0_eff = (dlc >= DLC_W'(1)) ? byte0 : '0;
        b1_eff = (dlc >= DLC_W'(2)) ? byte1 : '0;
        if (ide) begin
            word = {1'b1, id};
        end else begin
            word = {1'b0, id[ID_STD_W-1:0], b0_eff, b1_eff, {PAD_W{1'b0}}};
        end
    end

endmodule

// File: rtl/can_scr_filter_bank.sv
module can_scr_filter_bank
    import can_scr_pkg::*;
#(
    parameter int NUM_OBJ = 32,
    parameter int WR_W    = 32,
    localparam int OBJ_W  = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1,
    localparam int ADDR_W = OBJ_W + SEL_W
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [WR_W-1:0]    wr_data,
    input  logic [SCR_W-1:0]   scr,
    output logic [NUM_OBJ-1:0] hit_vec
);

    typedef struct packed {
        logic [NUM_OBJ-1:0][SCR_W-1:0]  match;
        logic [NUM_OBJ-1:0][MASK_W-1:0] mask;
        logic [NUM_OBJ-1:0]             en;
    } bank_t;

    bank_t bank_d;
    bank_t bank_q;

    logic [OBJ_W-1:0] wr_obj;
    reg_sel_e         wr_sel;

    assign wr_obj = wr_addr[ADDR_W-1:SEL_W];
    assign wr_sel = reg_sel_e'(wr_addr[SEL_W-1:0]);

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NUM_OBJ; i++) begin
            if (wr_en && (wr_obj == OBJ_W'(i))) begin
                unique case (wr_sel)
                    SEL_MATCH:  bank_d.match[i] = wr_data[SCR_W-1:0];
                    SEL_MASK:   bank_d.mask[i]  = wr_data[MASK_W-1:0];
                    SEL_ENABLE: bank_d.en[i]    = wr_data[0];
                    SEL_SPARE:  ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    // One comparator per object. The IDE bit sits above the mask and is always compared.
    for (genvar g = 0; g < NUM_OBJ; g++) begin : g_cmp
        logic [SCR_W-1:0] diff;
        assign diff       = (scr ^ bank_q.match[g]) & ~{1'b0, bank_q.mask[g]};
        assign hit_vec[g] = bank_q.en[g] && (diff == '0);

        assert_ide_unmasked_R5: assert property (@(posedge clk) disable iff (!rst_n)
            hit_vec[g] |-> (scr[IDE_POS] == bank_q.match[g][IDE_POS]));
    end

endmodule

// File: rtl/can_scr_prio.sv
module can_scr_prio #(
    parameter int N      = 32,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        any = 1'b0;
        idx = '0;
        // Scan from the top so that the lowest requester is written last.
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

    logic [N-1:0] below_idx;
    assign below_idx = ({{(N-1){1'b0}}, 1'b1} << idx) - {{(N-1){1'b0}}, 1'b1};

    assert_lowest_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (req[idx] && ((req & below_idx) == '0)));

endmodule

// File: rtl/can_screener_bank.sv
module can_screener_bank
    import can_scr_pkg::*;
#(
    parameter int NUM_OBJ = 32,
    parameter int WR_W    = 32,
    localparam int OBJ_W  = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1,
    localparam int ADDR_W = OBJ_W + SEL_W
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr_en,
    input  logic [ADDR_W-1:0]   cfg_wr_addr,
    input  logic [WR_W-1:0]     cfg_wr_data,
    input  logic                frm_valid,
    input  logic                frm_ide,
    input  logic [ID_EXT_W-1:0] frm_id,
    input  logic [DLC_W-1:0]    frm_dlc,
    input  logic [BYTE_W-1:0]   frm_byte0,
    input  logic [BYTE_W-1:0]   frm_byte1,
    output logic                acc_valid,
    output logic [OBJ_W-1:0]    acc_index,
    output logic                rej_valid
);

    typedef struct packed {
        logic             acc;
        logic             rej;
        logic [OBJ_W-1:0] idx;
    } result_t;

    result_t res_d;
    result_t res_q;

    logic [SCR_W-1:0]   scr_word;
    logic [NUM_OBJ-1:0] hit_vec;
    logic               hit_any;
    logic [OBJ_W-1:0]   hit_idx;

    can_scr_word_build u_build (
        .ide   (frm_ide),
        .id    (frm_id),
        .dlc   (frm_dlc),
        .byte0 (frm_byte0),
        .byte1 (frm_byte1),
        .word  (scr_word)
    );

    can_scr_filter_bank #(
        .NUM_OBJ (NUM_OBJ),
        .WR_W    (WR_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_addr (cfg_wr_addr),
        .wr_data (cfg_wr_data),
        .scr     (scr_word),
        .hit_vec (hit_vec)
    );

    can_scr_prio #(
        .N (NUM_OBJ)
    ) u_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (hit_vec),
        .any   (hit_any),
        .idx   (hit_idx)
    );

    always_comb begin
        res_d     = '0;
        res_d.acc = frm_valid && hit_any;
        res_d.rej = frm_valid && !hit_any;
        if (frm_valid && hit_any) begin
            res_d.idx = hit_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign acc_valid = res_q.acc;
    assign rej_valid = res_q.rej;
    assign acc_index = res_q.idx;

    assert_accept_after_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> $past(frm_valid));

    assert_strobe_answered_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> (acc_valid ^ rej_valid));

    assert_reject_after_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rej_valid |-> $past(frm_valid));

    assert_index_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> (acc_index == '0));

endmodule

// File: tb/can_screener_bank_test.sv
module can_screener_bank_test;

    localparam int CLK_PERIOD = 10;
    localparam int NOBJ = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [6:0]  cfg_wr_addr = '0;
    logic [31:0] cfg_wr_data = '0;
    logic        frm_valid = 1'b0;
    logic        frm_ide = 1'b0;
    logic [28:0] frm_id = '0;
    logic [3:0]  frm_dlc = '0;
    logic [7:0]  frm_byte0 = '0;
    logic [7:0]  frm_byte1 = '0;
    logic        acc_valid;
    logic [4:0]  acc_index;
    logic        rej_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [29:0] m_match [NOBJ];
    logic [28:0] m_mask  [NOBJ];
    bit          m_en    [NOBJ];

    always #(CLK_PERIOD / 2) clk = ~clk;

    can_screener_bank uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_addr (cfg_wr_addr),
        .cfg_wr_data (cfg_wr_data),
        .frm_valid   (frm_valid),
        .frm_ide     (frm_ide),
        .frm_id      (frm_id),
        .frm_dlc     (frm_dlc),
        .frm_byte0   (frm_byte0),
        .frm_byte1   (frm_byte1),
        .acc_valid   (acc_valid),
        .acc_index   (acc_index),
        .rej_valid   (rej_valid)
    );

    function automatic logic [29:0] ref_word(bit ide, logic [28:0] id, int dlc, int b0, int b1);
        longint w;
        int e0;
        int e1;
        e0 = (dlc >= 1) ? b0 : 0;
        e1 = (dlc >= 2) ? b1 : 0;
        if (ide) w = (longint'(1) << 29) + longint'(id);
        else     w = (longint'(id & 29'h7FF) << 18) + (longint'(e0) << 10) + (longint'(e1) << 2);
        return w[29:0];
    endfunction

    function automatic logic [29:0] ext_word(int id);
        return ref_word(1'b1, 29'(id), 0, 0, 0);
    endfunction

    task automatic check(bit e_acc, bit e_rej, int e_idx, string req);
        checks++;
        if (acc_valid !== e_acc || rej_valid !== e_rej || acc_index !== 5'(e_idx)) begin
            errors++;
            $display("FAIL %s: acc=%0b rej=%0b idx=%0d expected acc=%0b rej=%0b idx=%0d",
                     req, acc_valid, rej_valid, acc_index, e_acc, e_rej, e_idx);
        end
    endtask

    task automatic cycle(bit fv, bit ide, int id, int dlc, int b0, int b1,
                         bit we, int obj, int sel, logic [31:0] data, string req);
        bit e_acc;
        bit e_rej;
        int e_idx;
        logic [29:0] w;
        @(negedge clk);
        frm_valid   = fv;
        frm_ide     = ide;
        frm_id      = 29'(id);
        frm_dlc     = 4'(dlc);
        frm_byte0   = 8'(b0);
        frm_byte1   = 8'(b1);
        cfg_wr_en   = we;
        cfg_wr_addr = {5'(obj), 2'(sel)};
        cfg_wr_data = data;
        e_acc = 1'b0;
        e_rej = 1'b0;
        e_idx = 0;
        if (fv) begin
            w = ref_word(ide, 29'(id), dlc, b0, b1);
            for (int i = 0; i < NOBJ; i++) begin
                if (!e_acc && m_en[i] && (((w ^ m_match[i]) & ~{1'b0, m_mask[i]}) == 30'd0)) begin
                    e_acc = 1'b1;
                    e_idx = i;
                end
            end
            e_rej = !e_acc;
        end
        if (we) begin
            case (sel)
                0: m_match[obj] = data[29:0];
                1: m_mask[obj]  = data[28:0];
                2: m_en[obj]    = data[0];
                default: ;
            endcase
        end
        @(posedge clk);
        #1;
        check(e_acc, e_rej, e_idx, req);
    endtask

    task automatic wr(int obj, int sel, logic [31:0] data, string req);
        cycle(1'b0, 1'b0, 0, 0, 0, 0, 1'b1, obj, sel, data, req);
    endtask

    task automatic frm(bit ide, int id, int dlc, int b0, int b1, string req);
        cycle(1'b1, ide, id, dlc, b0, b1, 1'b0, 0, 0, 32'd0, req);
    endtask

    task automatic idle(string req);
        cycle(1'b0, 1'b0, 0, 0, 0, 0, 1'b0, 0, 0, 32'd0, req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NOBJ; i++) begin
            m_match[i] = '0;
            m_mask[i]  = '0;
            m_en[i]    = 1'b0;
        end
        repeat (3) @(posedge clk);
        #1;
        check(1'b0, 1'b0, 0, "R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        idle("R1 after reset");
        // All-zero frame equals the all-zero match words, but nothing is enabled.
        frm(1'b0, 0, 0, 0, 0, "R1 unprogrammed");

        // Extended exact match on object 5.
        wr(5, 0, {2'b00, ext_word(29'h1ABCDEF1)}, "R11");
        wr(5, 2, 32'd1, "R11");
        frm(1'b1, 29'h1ABCDEF1, 0, 0, 0, "R2 ext hit");
        idle("R8 single pulse");
        frm(1'b1, 29'h1ABCDEF0, 0, 0, 0, "R9 ext miss");
        idle("R9 single pulse");
        frm(1'b0, 29'h1ABCDEF1, 8, 8'hF1, 8'h00, "R2 format bit");

        // Standard frame with two payload bytes on object 3.
        wr(3, 0, {2'b00, ref_word(1'b0, 29'h5A3, 8, 8'h12, 8'h34)}, "R11");
        wr(3, 2, 32'd1, "R11");
        frm(1'b0, 29'h5A3, 8, 8'h12, 8'h34, "R3 std hit");
        frm(1'b0, 29'h5A3, 8, 8'h12, 8'h35, "R3 byte1 differs");
        frm(1'b0, 29'h1FFFF5A3, 8, 8'h12, 8'h34, "R3 upper id ignored");

        // Short frames: absent bytes count as zero.
        wr(9, 0, {2'b00, ref_word(1'b0, 29'h100, 1, 8'h77, 8'h00)}, "R11");
        wr(9, 2, 32'd1, "R11");
        frm(1'b0, 29'h100, 1, 8'h77, 8'hFF, "R4 dlc1 drops byte1");
        frm(1'b0, 29'h100, 0, 8'h77, 8'hFF, "R4 dlc0 drops byte0");
        wr(12, 0, {2'b00, ref_word(1'b0, 29'h100, 0, 0, 0)}, "R11");
        wr(12, 2, 32'd1, "R11");
        frm(1'b0, 29'h100, 0, 8'h77, 8'hFF, "R4 dlc0 zero bytes");

        // Mask families and the fixed IDE comparison.
        wr(10, 0, {2'b00, ext_word(29'h0A0)}, "R11");
        wr(10, 1, 32'h0000_000F, "R11");
        wr(10, 2, 32'd1, "R11");
        frm(1'b1, 29'h0A7, 0, 0, 0, "R5 masked low bits");
        frm(1'b1, 29'h0AF, 0, 0, 0, "R5 masked low bits");
        frm(1'b1, 29'h0B0, 0, 0, 0, "R5 unmasked bit differs");
        wr(11, 0, {2'b00, ext_word(0)}, "R11");
        wr(11, 1, 32'h1FFF_FFFF, "R11");
        wr(11, 2, 32'd1, "R11");
        frm(1'b1, 29'h12345, 0, 0, 0, "R5 full mask ext");
        frm(1'b0, 29'h200, 2, 8'h01, 8'h02, "R5 ide never masked");

        // Disable.
        wr(11, 2, 32'd0, "R11");
        frm(1'b1, 29'h12345, 0, 0, 0, "R6 disabled object");

        // Priority among overlapping objects.
        wr(20, 0, {2'b00, ext_word(29'h3333)}, "R11");
        wr(20, 2, 32'd1, "R11");
        frm(1'b1, 29'h3333, 0, 0, 0, "R7 single");
        wr(7, 0, {2'b00, ext_word(29'h3333)}, "R11");
        wr(7, 2, 32'd1, "R11");
        frm(1'b1, 29'h3333, 0, 0, 0, "R7 lower wins");
        wr(31, 0, {2'b00, ext_word(29'h4444)}, "R11");
        wr(31, 2, 32'd1, "R11");
        frm(1'b1, 29'h4444, 0, 0, 0, "R7 top object");
        wr(0, 0, {2'b00, ext_word(29'h4444)}, "R11");
        wr(0, 2, 32'd1, "R11");
        frm(1'b1, 29'h4444, 0, 0, 0, "R7 object zero wins");

        // Writes that coincide with a strobe.
        wr(25, 0, {2'b00, ext_word(29'h5555)}, "R11");
        cycle(1'b1, 1'b1, 29'h5555, 0, 0, 0, 1'b1, 25, 2, 32'd1, "R10 enable same cycle");
        frm(1'b1, 29'h5555, 0, 0, 0, "R10 enable seen later");
        cycle(1'b1, 1'b1, 29'h5555, 0, 0, 0, 1'b1, 25, 2, 32'd0, "R10 disable same cycle");
        frm(1'b1, 29'h5555, 0, 0, 0, "R10 disable seen later");
        cycle(1'b1, 1'b1, 29'h3333, 0, 0, 0, 1'b1, 7, 0, 32'd0, "R10 match write same cycle");
        frm(1'b1, 29'h3333, 0, 0, 0, "R10 match write seen later");

        // Spare selector and bits above the field widths.
        wr(0, 3, 32'd0, "R11 spare selector");
        frm(1'b1, 29'h4444, 0, 0, 0, "R11 spare selector no effect");
        wr(0, 0, 32'hC000_0000 | {2'b00, ext_word(29'h4444)}, "R11 wide data");
        frm(1'b1, 29'h4444, 0, 0, 0, "R11 upper data bits dropped");
        wr(31, 1, 32'hE000_0000, "R11 wide mask");
        wr(0, 2, 32'd0, "R11");
        frm(1'b0, 29'h4444, 0, 0, 0, "R11 mask upper bits dropped");
        frm(1'b1, 29'h4444, 0, 0, 0, "R7 next enabled object");
        idle("R8 idle after frame");

        finish_run();
    end

endmodule